// File: doc/BRIEF.md
# Pipeline Stage Weight Calibration Engine

This block sits behind a chain of 1-bit pipeline converter stages that end in a small backend quantizer. The analog stages are not part of it. Each front stage contributes its amplified reference, the product of gain and reference, to the result. Mismatch in the analog parts moves that product away from its ideal power-of-two value. At startup the engine measures the real contribution of every front stage. It holds the converter input and forces the stage decision low, then high, and digitizes the residue both times through the stages behind it. The difference of the two readings is the stage's true weight, and it is written into a small per-stage weight store.

Stages are measured from the back towards the front. The reading taken for stage k therefore uses only weights that have already been measured, plus the raw backend code. Before any measurement, each entry of the store holds its ideal weight. In normal operation the engine forms the output code as the backend code plus the stored weight of every stage whose decision bit is 1. A two-cycle registered adder tree does this sum.

Top module: `stage_weight_cal`

## Requirements
- R1: After reset, `done_o` is 0, `force_sel_o` is all zero and `force_d_o` is 0. The stored weight of stage k is 2^(LAST_W-1+N_STAGES-1-k), so with the defaults stage 0 holds 512 and stage 5 holds 16.
- R2: `cal_out_o` equals `last_code_i` plus the sum of the stored weights of every stage k with `stage_bits_i[k]`=1. Bit k of `stage_bits_i` is stage k, and stage 0 is the first (heaviest) stage. The output reflects the inputs applied two rising edges earlier.
- R3: A `start_i` seen while idle or finished begins calibration. On the next edge `done_o` falls, and stage N_STAGES-1 is the first stage forced.
- R4: During calibration `force_sel_o` is one-hot on the stage under measurement, and stages are visited in the order N_STAGES-1 down to 0. For each stage, a phase with `force_d_o`=0 comes before a phase with `force_d_o`=1, and the selection does not change between the two.
- R5: In each phase, the reading is sampled on the (`settle_i`+1)-th rising edge after the edge at which a rising `backend_valid_i` is first seen in that phase. Data present only at the strobe edge is not used when `settle_i` is at least 1.
- R6: The reading for stage k is `last_code_i` plus the stored weights of the stages j>k whose `stage_bits_i[j]` is 1. Bits of stage k and of the stages before it do not affect it.
- R7: The weight stored for stage k is the force-low reading minus the force-high reading, modulo 2^WGT_W.
- R8: After stage 0 is stored, `done_o` rises and stays high with no stage forced until the next `start_i`.
- R9: A `start_i` asserted while calibration is in progress is ignored, and the sequence carries on with the same stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin calibration |
| settle_i | input | SETTLE_W | Edges to wait after the backend strobe before sampling |
| stage_bits_i | input | N_STAGES | Decision bit of each front stage |
| last_code_i | input | LAST_W | Raw backend quantizer code |
| backend_valid_i | input | 1 | Backend result strobe, rising-edge detected |
| force_sel_o | output | N_STAGES | One-hot stage whose decision is forced |
| force_d_o | output | 1 | Forced decision value |
| cal_out_o | output | WGT_W+clog2(N_STAGES+1) | Calibrated output code |
| done_o | output | 1 | Calibration complete |

## Verification
The bench uses the defaults: six front stages, a 5-bit backend code, 10-bit weights and a 4-bit settle count. With these, one calibration pass takes a few hundred cycles, every stage position can be probed one at a time, and the one bit of backend overrange lets the last front stage be measured with the backend code alone. A first pass runs with `settle_i`=3, and at each strobe edge the bench presents junk data that is replaced one cycle later. This shows whether the sampling point is correct. A second pass runs with `settle_i`=0 and clean data. Measured weights are read back through the runtime path by driving one-hot stage bits with a zero backend code.

// File: rtl/stwcal_pkg.sv
package stwcal_pkg;
  typedef enum logic [2:0] {
    CS_IDLE,
    CS_FORCE_LO,
    CS_HOLD_LO,
    CS_FORCE_HI,
    CS_HOLD_HI,
    CS_WRITE,
    CS_STEP,
    CS_FINISH
  } cal_state_e;
endpackage

// File: rtl/stwcal_ram.sv
module stwcal_ram #(
  parameter int N_STAGES = 6,
  parameter int WGT_W    = 10,
  parameter int LAST_W   = 5,
  parameter int IDX_W    = 3
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               we_i,
  input  logic [IDX_W-1:0]                   waddr_i,
  input  logic [WGT_W-1:0]                   wdata_i,
  output logic [N_STAGES-1:0][WGT_W-1:0]     weights_o
);

  for (genvar k = 0; k < N_STAGES; k++) begin : g_ent
    localparam int SHIFT = LAST_W + N_STAGES - 2 - k;
    logic [WGT_W-1:0] w_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  w_q <= WGT_W'(1) << SHIFT;
      else if (we_i && (waddr_i == IDX_W'(k)))      w_q <= wdata_i;
    end
    assign weights_o[k] = w_q;
  end

endmodule

// File: rtl/stwcal_recon.sv
// Backend reading: raw code plus stored weights of stages behind idx_i.
module stwcal_recon #(
  parameter int N_STAGES = 6,
  parameter int WGT_W    = 10,
  parameter int LAST_W   = 5,
  parameter int SUM_W    = 13,
  parameter int IDX_W    = 3
) (
  input  logic [N_STAGES-1:0][WGT_W-1:0] weights_i,
  input  logic [N_STAGES-1:0]            bits_i,
  input  logic [LAST_W-1:0]              last_i,
  input  logic [IDX_W-1:0]               idx_i,
  output logic [SUM_W-1:0]               sum_o
);

  always_comb begin
    sum_o = SUM_W'(last_i);
    for (int j = 0; j < N_STAGES; j++) begin
      if ((j > int'(idx_i)) && bits_i[j]) sum_o = sum_o + SUM_W'(weights_i[j]);
    end
  end

endmodule

// File: rtl/stwcal_tree.sv
// Runtime sum: stage 1 registers selected terms, stage 2 registers their total.
module stwcal_tree #(
  parameter int N_STAGES = 6,
  parameter int WGT_W    = 10,
  parameter int LAST_W   = 5,
  parameter int SUM_W    = 13
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [N_STAGES-1:0][WGT_W-1:0] weights_i,
  input  logic [N_STAGES-1:0]            bits_i,
  input  logic [LAST_W-1:0]              last_i,
  output logic [SUM_W-1:0]               sum_o
);

  logic [N_STAGES-1:0][WGT_W-1:0] term_q;
  logic [LAST_W-1:0]              last_q;
  logic [SUM_W-1:0]               total;
  logic [SUM_W-1:0]               sum_q;

  for (genvar j = 0; j < N_STAGES; j++) begin : g_term
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) term_q[j] <= '0;
      else         term_q[j] <= bits_i[j] ? weights_i[j] : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= '0;
    else         last_q <= last_i;
  end

  always_comb begin
    total = SUM_W'(last_q);
    for (int j = 0; j < N_STAGES; j++) total = total + SUM_W'(term_q[j]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_q <= '0;
    else         sum_q <= total;
  end

  assign sum_o = sum_q;

endmodule

// File: rtl/stwcal_fsm.sv
module stwcal_fsm
  import stwcal_pkg::*;
#(
  parameter int N_STAGES = 6,
  parameter int WGT_W    = 10,
  parameter int SUM_W    = 13,
  parameter int SETTLE_W = 4,
  parameter int IDX_W    = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic                backend_valid_i,
  input  logic [SUM_W-1:0]    reading_i,
  output logic [IDX_W-1:0]    idx_o,
  output logic                we_o,
  output logic [WGT_W-1:0]    wdata_o,
  output logic [N_STAGES-1:0] force_sel_o,
  output logic                force_d_o,
  output logic                done_o,
  output cal_state_e          state_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_STAGES - 1);

  cal_state_e          state_q;
  logic [IDX_W-1:0]    idx_q;
  logic                armed_q;
  logic [SETTLE_W-1:0] cnt_q;
  logic                vld_q;
  logic [SUM_W-1:0]    rd_a_q;
  logic [SUM_W-1:0]    rd_b_q;

  logic rise;
  logic sample_now;
  logic holding;

  assign rise       = backend_valid_i && !vld_q;
  assign sample_now = armed_q && (cnt_q == settle_i);
  assign holding    = (state_q == CS_HOLD_LO) || (state_q == CS_HOLD_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= backend_valid_i;
  end

  // settle counter, only live in the hold states
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!holding || sample_now) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (armed_q) begin
      cnt_q   <= cnt_q + 1'b1;
    end else if (rise) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CS_IDLE;
      idx_q   <= '0;
      rd_a_q  <= '0;
      rd_b_q  <= '0;
    end else begin
      unique case (state_q)
        CS_IDLE, CS_FINISH: begin
          if (start_i) begin
            state_q <= CS_FORCE_LO;
            idx_q   <= LAST_IDX;
          end
        end
        CS_FORCE_LO: state_q <= CS_HOLD_LO;
        CS_HOLD_LO: begin
          if (sample_now) begin
            rd_a_q  <= reading_i;
            state_q <= CS_FORCE_HI;
          end
        end
        CS_FORCE_HI: state_q <= CS_HOLD_HI;
        CS_HOLD_HI: begin
          if (sample_now) begin
            rd_b_q  <= reading_i;
            state_q <= CS_WRITE;
          end
        end
        CS_WRITE: state_q <= CS_STEP;
        CS_STEP: begin
          if (idx_q == '0) begin
            state_q <= CS_FINISH;
          end else begin
            idx_q   <= idx_q - 1'b1;
            state_q <= CS_FORCE_LO;
          end
        end
        default: state_q <= CS_IDLE;
      endcase
    end
  end

  always_comb begin
    force_sel_o = '0;
    if ((state_q == CS_FORCE_LO) || (state_q == CS_HOLD_LO) ||
        (state_q == CS_FORCE_HI) || (state_q == CS_HOLD_HI))
      force_sel_o[idx_q] = 1'b1;
  end

  assign force_d_o = (state_q == CS_FORCE_HI) || (state_q == CS_HOLD_HI);
  assign done_o    = (state_q == CS_FINISH);
  assign we_o      = (state_q == CS_WRITE);
  assign wdata_o   = WGT_W'(rd_a_q - rd_b_q);
  assign idx_o     = idx_q;
  assign state_o   = state_q;

endmodule

// File: rtl/stage_weight_cal.sv
module stage_weight_cal
  import stwcal_pkg::*;
#(
  parameter int N_STAGES = 6,
  parameter int LAST_W   = 5,
  parameter int WGT_W    = 10,
  parameter int SETTLE_W = 4,
  localparam int SUM_W   = WGT_W + $clog2(N_STAGES + 1),
  localparam int IDX_W   = (N_STAGES > 1) ? $clog2(N_STAGES) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic [N_STAGES-1:0] stage_bits_i,
  input  logic [LAST_W-1:0]   last_code_i,
  input  logic                backend_valid_i,
  output logic [N_STAGES-1:0] force_sel_o,
  output logic                force_d_o,
  output logic [SUM_W-1:0]    cal_out_o,
  output logic                done_o
);

  logic [N_STAGES-1:0][WGT_W-1:0] weights;
  logic [IDX_W-1:0]               cal_idx;
  logic                           wr_en;
  logic [WGT_W-1:0]               wr_data;
  logic [SUM_W-1:0]               reading;
  cal_state_e                     cal_state;

  stwcal_ram #(
    .N_STAGES(N_STAGES), .WGT_W(WGT_W), .LAST_W(LAST_W), .IDX_W(IDX_W)
  ) u_ram (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_en), .waddr_i(cal_idx),
    .wdata_i(wr_data), .weights_o(weights)
  );

  stwcal_recon #(
    .N_STAGES(N_STAGES), .WGT_W(WGT_W), .LAST_W(LAST_W), .SUM_W(SUM_W), .IDX_W(IDX_W)
  ) u_recon (
    .weights_i(weights), .bits_i(stage_bits_i), .last_i(last_code_i),
    .idx_i(cal_idx), .sum_o(reading)
  );

  stwcal_fsm #(
    .N_STAGES(N_STAGES), .WGT_W(WGT_W), .SUM_W(SUM_W), .SETTLE_W(SETTLE_W), .IDX_W(IDX_W)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .settle_i(settle_i),
    .backend_valid_i(backend_valid_i), .reading_i(reading), .idx_o(cal_idx),
    .we_o(wr_en), .wdata_o(wr_data), .force_sel_o(force_sel_o),
    .force_d_o(force_d_o), .done_o(done_o), .state_o(cal_state)
  );

  stwcal_tree #(
    .N_STAGES(N_STAGES), .WGT_W(WGT_W), .LAST_W(LAST_W), .SUM_W(SUM_W)
  ) u_tree (
    .clk_i(clk_i), .rst_ni(rst_ni), .weights_i(weights), .bits_i(stage_bits_i),
    .last_i(last_code_i), .sum_o(cal_out_o)
  );

endmodule

// File: rtl/stwcal_chk.sv
module stwcal_chk
  import stwcal_pkg::*;
#(
  parameter int N_STAGES = 6,
  parameter int LAST_W   = 5,
  parameter int SUM_W    = 13
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic [N_STAGES-1:0] stage_bits_i,
  input logic [LAST_W-1:0]   last_code_i,
  input logic [N_STAGES-1:0] force_sel_o,
  input logic                force_d_o,
  input logic [SUM_W-1:0]    cal_out_o,
  input logic                done_o,
  input logic [2:0]          cal_state
);

  logic [1:0] cyc_q;
  logic       busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 1'b1;
  end

  assign busy = (cal_state != 3'(CS_IDLE)) && (cal_state != 3'(CS_FINISH));

  p_sel_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(force_sel_o));

  p_hi_same_stage_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != 2'd0 && $rose(force_d_o)) |-> ($stable(force_sel_o) && force_sel_o != '0));

  p_start_begins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> (!done_o && force_sel_o[N_STAGES-1] && !force_d_o));

  p_done_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (force_sel_o == '0 && !force_d_o));

  p_done_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && start_i) |=> (cal_state != 3'(CS_FORCE_LO) || $past(cal_state) == 3'(CS_STEP)));

  p_backend_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd3 && $past(stage_bits_i, 2) == '0) |-> cal_out_o == SUM_W'($past(last_code_i, 2)));

endmodule

bind stage_weight_cal stwcal_chk #(
  .N_STAGES(N_STAGES), .LAST_W(LAST_W), .SUM_W(SUM_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .stage_bits_i(stage_bits_i),
  .last_code_i(last_code_i), .force_sel_o(force_sel_o), .force_d_o(force_d_o),
  .cal_out_o(cal_out_o), .done_o(done_o), .cal_state(cal_state)
);

// File: tb/stage_weight_cal_tb.sv
module stage_weight_cal_tb;
  localparam int N      = 6;
  localparam int LW     = 5;
  localparam int WW     = 10;
  localparam int SW     = 4;
  localparam int OW     = WW + $clog2(N + 1);
  localparam logic [N-1:0] ALL = '1;

  localparam logic [N+LW-1:0] VEC [0:7] = '{
    {6'b000000, 5'd0},  {6'b111111, 5'd31}, {6'b000001, 5'd7},  {6'b100000, 5'd1},
    {6'b101010, 5'd5},  {6'b010101, 5'd30}, {6'b110011, 5'd16}, {6'b001100, 5'd9}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [SW-1:0] settle = '0;
  logic [N-1:0]  bits = '0;
  logic [LW-1:0] last = '0;
  logic          bvalid = 1'b0;
  logic [N-1:0]  fsel;
  logic          fd;
  logic [OW-1:0] out;
  logic          done;

  int n_chk = 0;
  int n_bad = 0;
  int w_mod [N];

  always #10 clk = ~clk;

  stage_weight_cal u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .settle_i(settle),
    .stage_bits_i(bits), .last_code_i(last), .backend_valid_i(bvalid),
    .force_sel_o(fsel), .force_d_o(fd), .cal_out_o(out), .done_o(done)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model_sum(input logic [N-1:0] b, input logic [LW-1:0] l, input int above);
    int s = int'(l);
    for (int j = 0; j < N; j++) if (j > above && b[j]) s += w_mod[j];
    return s;
  endfunction

  task automatic walk_vectors(input string tag);
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      {bits, last} = VEC[v];
      @(negedge clk);
      @(negedge clk);
      chk(tag, out, model_sum(VEC[v][N+LW-1:LW], VEC[v][LW-1:0], -1));
    end
  endtask

  task automatic probe_weights(input string tag);
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      bits = N'(1) << k;
      last = '0;
      @(negedge clk);
      @(negedge clk);
      chk(tag, out, w_mod[k]);
    end
  endtask

  task automatic phase(input int k, input bit d, input bit junk, input bit poke, output int rd);
    logic [N-1:0] above, pat;
    logic [LW-1:0] lc;
    logic [N-1:0] exp_sel;
    bit stray = 0;
    exp_sel = N'(1) << k;
    above = ALL & ~((N'(1) << (k + 1)) - N'(1));
    if (!d) begin
      pat = above | (6'b010101 & ~above);
      lc  = LW'(20 + k);
    end else begin
      pat = (above & 6'b100110) | (~above & 6'b101010);
      lc  = LW'(3);
    end
    while (!(fsel == exp_sel && fd == d)) begin
      if (fsel != '0 && fsel != exp_sel && fsel != (exp_sel << 1)) stray = 1;
      @(negedge clk);
    end
    chk("R4 stage order", stray, 0);
    @(negedge clk);
    if (poke) begin
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R9 start ignored sel", fsel, exp_sel);
      chk("R9 start ignored d", fd, 0);
    end
    if (junk) begin
      bits = ~pat; last = ~lc; bvalid = 1'b1;
      @(negedge clk);
      bvalid = 1'b0; bits = pat; last = lc;
    end else begin
      bits = pat; last = lc; bvalid = 1'b1;
      @(negedge clk);
      bvalid = 1'b0;
    end
    rd = model_sum(pat, lc, k);
  endtask

  task automatic run_cal(input bit junk, input bit poke);
    int ra, rb;
    for (int k = N - 1; k >= 0; k--) begin
      phase(k, 1'b0, junk, poke && (k == 3), ra);
      phase(k, 1'b1, junk, 1'b0, rb);
      w_mod[k] = (ra - rb) & ((1 << WW) - 1);
    end
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) w_mod[k] = 1 << (LW - 1 + N - 1 - k);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done low", done, 0);
    chk("R1 no force", fsel, 0);
    chk("R1 force d low", fd, 0);
    probe_weights("R1 ideal weight");
    walk_vectors("R2 ideal sum");

    // R2 latency: output still old one edge after a change
    @(negedge clk);
    bits = '0; last = '0;
    @(negedge clk);
    @(negedge clk);
    bits = ALL; last = 5'd31;
    @(negedge clk);
    chk("R2 latency 1 edge", out, 0);
    @(negedge clk);
    chk("R2 latency 2 edges", out, model_sum(ALL, 5'd31, -1));

    // first pass: settle 3, junk at strobe edge, start poked mid-run
    settle = 4'd3;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R3 first stage", fsel, N'(1) << (N - 1));
    chk("R3 done low", done, 0);
    run_cal(1'b1, 1'b1);
    chk("R8 done high", done, 1);
    probe_weights("R5/R6/R7 measured weight");
    walk_vectors("R2 calibrated sum");
    repeat (20) @(negedge clk);
    chk("R8 done held", done, 1);
    chk("R8 no force", fsel, 0);

    // second pass: settle 0, clean data
    settle = 4'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R3 restart done low", done, 0);
    chk("R3 restart stage", fsel, N'(1) << (N - 1));
    run_cal(1'b0, 1'b0);
    chk("R8 done again", done, 1);
    probe_weights("R5/R6/R7 second pass weight");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule